// File: doc/BRIEF.md
# Serial Audio Transmitter with Packed Sample Queue

This block drives a two-wire serial audio link: a word-select line that marks the left and right halves of each frame, and a serial data line that carries each sample MSB first. A host pushes 32-bit words into an eight-entry queue. At the start of every frame the block takes one or two words from the queue and splits them into a left and a right sample. How it splits them depends on the configured sample width (8, 16 or 32 bits) and on whether the stream is mono or stereo. The bit rate is set by a one-cycle tick from an external divider. Each half-frame lasts a programmed number of ticks, and that count is set separately from the sample width.

Software programs width, channel mode and half-frame length in a single configuration write. That write also stops the transmitter, empties the queue and puts the frame position back at its start. Start and stop strobes switch between running and muted operation. A flush strobe empties the queue. The current fill level is visible at all times. A level flag is raised while the fill level is at or below a programmable threshold, so a host or DMA engine knows when to refill the queue.

Top module: `audio_ser_tx`

## Requirements
- R1: After reset, and in the cycle after a configuration write, the block is stopped, the queue is empty, and `ws_out` and `sd_out` are 0. The next tick begins a left half-frame.
- R2: The queue holds 8 words. A host write is accepted only while running and while the level is below 8; other writes are dropped. `fifo_level` shows the number of stored words.
- R3: Each half-frame lasts `cfg_half` ticks, with `ws_out` at 0 for the left half and 1 for the right half. In each half, slot 0 carries 0, slots 1..W carry the sample MSB first, and later slots carry 0. The outputs change only on cycles where `bclk_en` is high.
- R4: Width code 2'b01 is 16 bits and 2'b00 is 8 bits. In stereo (`cfg_mono`=0), one word makes one frame. For 16 bits the left sample is bits [15:0] and the right sample is bits [31:16]. For 8 bits the left sample is bits [7:0] and the right sample is bits [15:8].
- R5: In mono (`cfg_mono`=1), one word makes one frame, and its low W bits are sent in both halves.
- R6: Width code 2'b11 is 32 bits. In 32-bit stereo a frame uses two words, the first for left and the second for right. With fewer than two words stored, the frame is silent and nothing is removed from the queue.
- R7: If the queue cannot supply a frame, `sd_out` stays 0 for that frame and `ws_out` keeps toggling.
- R8: While stopped, `sd_out` is 0, host writes are dropped, and stored words are neither removed nor lost. A start strobe resumes sending at the next frame.
- R9: A flush strobe empties the queue.
- R10: `level_irq` is 1 exactly when `fifo_level` is less than or equal to `irq_thresh`.
- R11: A configuration write with the reserved width code 2'b10 keeps the previous width. The mode and half-frame fields of that write still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bclk_en | input | 1 | One-cycle bit tick from an external divider |
| cfg_wr | input | 1 | Configuration write strobe; also stops the block and resets it |
| cfg_width | input | 2 | Width code: 00 = 8-bit, 01 = 16-bit, 11 = 32-bit, 10 = reserved |
| cfg_mono | input | 1 | 1 = mono, 0 = stereo |
| cfg_half | input | HALF_W | Half-frame length in ticks |
| run_start | input | 1 | Start strobe (unmute) |
| run_stop | input | 1 | Stop strobe (mute) |
| fifo_flush | input | 1 | Empties the queue |
| wr_valid | input | 1 | Host write strobe |
| wr_data | input | 32 | Host write word |
| irq_thresh | input | LVL_W | Threshold for the level flag |
| ws_out | output | 1 | Word select: 0 = left, 1 = right |
| sd_out | output | 1 | Serial data, MSB first |
| fifo_level | output | LVL_W | Number of stored words |
| level_irq | output | 1 | High while the level is at or below the threshold |

## Verification
The bench builds the block with its default parameters: a depth of 8 and a 7-bit half-frame field. With these values the half-frame can be set to 34 ticks, so every bit of a 32-bit sample fits, and the queue can be filled past capacity to exercise dropped writes. Short half-frames of 10 to 20 ticks keep the 8- and 16-bit frames fast. They also leave trailing pad slots, which the bench checks for zeros. All three widths are run in both channel modes where the requirements define them, along with underrun, a partial 32-bit pair, mute with retained contents, and a reserved width code.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        WID_8   = 2'b00,
        WID_16  = 2'b01,
        WID_RSV = 2'b10,
        WID_32  = 2'b11
    } width_e;

    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
    } frame_t;

    function automatic int unsigned width_bits(width_e w);
        case (w)
            WID_8:   return 8;
            WID_16:  return 16;
            default: return 32;
        endcase
    endfunction

    function automatic logic width_legal(logic [1:0] code);
        return code != 2'b10;
    endfunction

endpackage

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    parameter int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic [1:0]       pop_n,
    output logic [DW-1:0]    head0,
    output logic [DW-1:0]    head1,
    output logic [LVL_W-1:0] level
);
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] rptr, wptr;
    logic          accept;

    assign accept = push && (32'(level) < DEPTH);
    assign head0  = mem[rptr];
    assign head1  = mem[rptr + AW'(1)];

    always_ff @(posedge clk) begin
        if (accept) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rptr  <= '0;
            wptr  <= '0;
            level <= '0;
        end else begin
            if (accept) wptr <= wptr + AW'(1);
            rptr  <= rptr + AW'(pop_n);
            level <= level + LVL_W'(accept) - LVL_W'(pop_n);
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        32'(level) <= DEPTH);

    assert_pop_within_level_R6: assert property (@(posedge clk) disable iff (rst)
        LVL_W'(pop_n) <= level);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        clear |=> level == '0);

endmodule

// File: rtl/audio_tx_unpack.sv
module audio_tx_unpack
    import audio_tx_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  width_e           width,
    input  logic             mono,
    input  logic [31:0]      word0,
    input  logic [31:0]      word1,
    input  logic [LVL_W-1:0] level,
    output frame_t           frame,
    output logic [1:0]       need,
    output logic             ok
);
    always_comb begin
        need = 2'd1;
        frame.left  = '0;
        frame.right = '0;
        case (width)
            WID_8: begin
                frame.left  = {24'b0, word0[7:0]};
                frame.right = mono ? {24'b0, word0[7:0]} : {24'b0, word0[15:8]};
            end
            WID_16: begin
                frame.left  = {16'b0, word0[15:0]};
                frame.right = mono ? {16'b0, word0[15:0]} : {16'b0, word0[31:16]};
            end
            default: begin
                frame.left  = word0;
                frame.right = mono ? word0 : word1;
                need        = mono ? 2'd1 : 2'd2;
            end
        endcase
        ok = level >= LVL_W'(need);
    end
endmodule

// File: rtl/audio_tx_serializer.sv
module audio_tx_serializer
    import audio_tx_pkg::*;
#(
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              tick,
    input  logic              running,
    input  logic [HALF_W-1:0] half,
    input  width_e            width,
    input  frame_t            frame_in,
    input  logic              frame_ok,
    input  logic [1:0]        need,
    output logic [1:0]        pop_n,
    output logic              ws_out,
    output logic              sd_out
);
    logic [HALF_W-1:0] pos, last;
    logic              side;
    frame_t            hold;
    logic [31:0]       cur;
    logic              bit_now;
    logic              frame_start;
    int unsigned       wbits;

    assign last        = (half == '0) ? '0 : half - HALF_W'(1);
    assign frame_start = !side && (pos == '0);
    assign pop_n       = (tick && frame_start && running && frame_ok) ? need : 2'd0;

    always_comb begin
        wbits   = width_bits(width);
        cur     = side ? hold.right : hold.left;
        bit_now = 1'b0;
        if (pos != '0 && 32'(pos) <= wbits)
            bit_now = cur[5'(wbits - 32'(pos))];
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pos    <= '0;
            side   <= 1'b0;
            ws_out <= 1'b0;
            sd_out <= 1'b0;
            hold   <= '0;
        end else begin
            if (!running) hold <= '0;
            if (tick) begin
                ws_out <= side;
                sd_out <= running && bit_now;
                if (frame_start)
                    hold <= (running && frame_ok) ? frame_in : '0;
                if (pos >= last) begin
                    pos  <= '0;
                    side <= !side;
                end else begin
                    pos <= pos + HALF_W'(1);
                end
            end
        end
    end

    assert_mute_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (!running && tick) |=> !sd_out);

    assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> ($stable(ws_out) && $stable(sd_out)));

endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx
    import audio_tx_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int HALF_W   = 7,
    parameter int DEF_HALF = 16,
    parameter int LVL_W    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bclk_en,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_mono,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic              run_start,
    input  logic              run_stop,
    input  logic              fifo_flush,
    input  logic              wr_valid,
    input  logic [31:0]       wr_data,
    input  logic [LVL_W-1:0]  irq_thresh,
    output logic              ws_out,
    output logic              sd_out,
    output logic [LVL_W-1:0]  fifo_level,
    output logic              level_irq
);
    width_e            width_q;
    logic              mono_q;
    logic [HALF_W-1:0] half_q;
    logic              running_q;

    logic [31:0] head0, head1;
    logic [1:0]  pop_n, need;
    frame_t      frame;
    logic        frame_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q   <= WID_16;
            mono_q    <= 1'b0;
            half_q    <= HALF_W'(DEF_HALF);
            running_q <= 1'b0;
        end else if (cfg_wr) begin
            if (width_legal(cfg_width)) width_q <= width_e'(cfg_width);
            mono_q    <= cfg_mono;
            half_q    <= cfg_half;
            running_q <= 1'b0;
        end else if (run_stop) begin
            running_q <= 1'b0;
        end else if (run_start) begin
            running_q <= 1'b1;
        end
    end

    audio_tx_fifo #(.DEPTH(DEPTH), .DW(32), .LVL_W(LVL_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .clear     (cfg_wr || fifo_flush),
        .push      (wr_valid && running_q),
        .push_data (wr_data),
        .pop_n     (pop_n),
        .head0     (head0),
        .head1     (head1),
        .level     (fifo_level)
    );

    audio_tx_unpack #(.LVL_W(LVL_W)) u_unpack (
        .width (width_q),
        .mono  (mono_q),
        .word0 (head0),
        .word1 (head1),
        .level (fifo_level),
        .frame (frame),
        .need  (need),
        .ok    (frame_ok)
    );

    audio_tx_serializer #(.HALF_W(HALF_W)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .restart  (cfg_wr),
        .tick     (bclk_en),
        .running  (running_q),
        .half     (half_q),
        .width    (width_q),
        .frame_in (frame),
        .frame_ok (frame_ok),
        .need     (need),
        .pop_n    (pop_n),
        .ws_out   (ws_out),
        .sd_out   (sd_out)
    );

    assign level_irq = fifo_level <= irq_thresh;

    assert_cfg_resets_R1: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (!running_q && fifo_level == '0 && !ws_out && !sd_out));

    assert_reserved_keeps_width_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && cfg_width == 2'b10) |=> width_q == $past(width_q));

endmodule

// File: tb/audio_ser_tx_bench.sv
module audio_ser_tx_bench;
    localparam int HALF_W = 7;
    localparam int LVL_W  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bclk_en = 1'b0;
    logic              cfg_wr = 1'b0;
    logic [1:0]        cfg_width = 2'b01;
    logic              cfg_mono = 1'b0;
    logic [HALF_W-1:0] cfg_half = '0;
    logic              run_start = 1'b0, run_stop = 1'b0, fifo_flush = 1'b0;
    logic              wr_valid = 1'b0;
    logic [31:0]       wr_data = '0;
    logic [LVL_W-1:0]  irq_thresh = '0;
    logic              ws_out, sd_out, level_irq;
    logic [LVL_W-1:0]  fifo_level;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    audio_ser_tx u_audio_ser_tx (
        .clk(clk), .rst(rst), .bclk_en(bclk_en), .cfg_wr(cfg_wr),
        .cfg_width(cfg_width), .cfg_mono(cfg_mono), .cfg_half(cfg_half),
        .run_start(run_start), .run_stop(run_stop), .fifo_flush(fifo_flush),
        .wr_valid(wr_valid), .wr_data(wr_data), .irq_thresh(irq_thresh),
        .ws_out(ws_out), .sd_out(sd_out), .fifo_level(fifo_level),
        .level_irq(level_irq)
    );

    task automatic chk(input bit cond, input string tag, input longint act, input longint exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic configure(input logic [1:0] w, input logic m, input int h);
        @(negedge clk);
        cfg_width = w; cfg_mono = m; cfg_half = HALF_W'(h); cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); run_start = 1'b1; @(negedge clk); run_start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); run_stop = 1'b1; @(negedge clk); run_stop = 1'b0;
    endtask

    task automatic pulse_flush();
        @(negedge clk); fifo_flush = 1'b1; @(negedge clk); fifo_flush = 1'b0;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); wr_valid = 1'b1; wr_data = d;
        @(negedge clk); wr_valid = 1'b0;
    endtask

    task automatic tick(output logic ws, output logic sd);
        @(negedge clk); bclk_en = 1'b1;
        @(negedge clk); bclk_en = 1'b0;
        ws = ws_out; sd = sd_out;
    endtask

    // Captures one whole frame from its first tick; counts ws and padding errors.
    task automatic frame(input int h, input int w, output logic [31:0] l,
                         output logic [31:0] r, output int ws_err, output int pad_err);
        logic ws, sd;
        l = '0; r = '0; ws_err = 0; pad_err = 0;
        for (int k = 0; k < 2 * h; k++) begin
            automatic int j = k % h;
            automatic logic side = (k >= h);
            tick(ws, sd);
            if (ws !== side) ws_err++;
            if (j >= 1 && j <= w) begin
                if (!side) l = {l[30:0], sd};
                else       r = {r[30:0], sd};
            end else if (sd !== 1'b0) begin
                pad_err++;
            end
        end
    endtask

    task automatic t_reset();
        chk(ws_out === 1'b0, "R1 reset ws", ws_out, 0);
        chk(sd_out === 1'b0, "R1 reset sd", sd_out, 0);
        chk(fifo_level === 0, "R1 reset level", fifo_level, 0);
        chk(level_irq === 1'b1, "R10 reset irq", level_irq, 1);
    endtask

    task automatic t_stereo16();
        logic [31:0] l, r; int we, pe;
        configure(2'b01, 1'b0, 20); pulse_start();
        push(32'hB3C1_5A0F); push(32'h1234_8765);
        chk(fifo_level === 2, "R2 level after two writes", fifo_level, 2);
        frame(20, 16, l, r, we, pe);
        chk(l === 32'h5A0F, "R4 s16 left", l, 32'h5A0F);
        chk(r === 32'hB3C1, "R4 s16 right", r, 32'hB3C1);
        chk(we == 0 && pe == 0, "R3 s16 ws/pad", we * 100 + pe, 0);
        chk(fifo_level === 1, "R4 one word per frame", fifo_level, 1);
        frame(20, 16, l, r, we, pe);
        chk(l === 32'h8765 && r === 32'h1234, "R4 s16 second frame", {l[15:0], r[15:0]}, 32'h8765_1234);
    endtask

    task automatic t_stereo8();
        logic [31:0] l, r; int we, pe;
        configure(2'b00, 1'b0, 12); pulse_start();
        push(32'hFFEE_C35A);
        frame(12, 8, l, r, we, pe);
        chk(l === 32'h5A && r === 32'hC3, "R4 s8 bytes", {l[7:0], r[7:0]}, 16'h5AC3);
        chk(pe == 0 && we == 0, "R3 s8 pad slots zero", pe, 0);
    endtask

    task automatic t_mono16();
        logic [31:0] l, r; int we, pe;
        configure(2'b01, 1'b1, 20); pulse_start();
        push(32'h7777_9A5C); push(32'h0000_0001);
        frame(20, 16, l, r, we, pe);
        chk(l === 32'h9A5C && r === 32'h9A5C, "R5 mono both halves", {l[15:0], r[15:0]}, 32'h9A5C_9A5C);
        chk(fifo_level === 1, "R5 mono pops one", fifo_level, 1);
    endtask

    task automatic t_stereo32();
        logic [31:0] l, r; int we, pe;
        configure(2'b11, 1'b0, 34); pulse_start();
        push(32'hDEAD_BEEF); push(32'h8001_0203);
        frame(34, 32, l, r, we, pe);
        chk(l === 32'hDEAD_BEEF, "R6 s32 left", l, 32'hDEAD_BEEF);
        chk(r === 32'h8001_0203, "R6 s32 right", r, 32'h8001_0203);
        chk(fifo_level === 0, "R6 two words popped", fifo_level, 0);
        push(32'hCAFE_F00D);
        frame(34, 32, l, r, we, pe);
        chk(l === 0 && r === 0, "R6 partial pair silent", l | r, 0);
        chk(fifo_level === 1, "R6 partial pair kept", fifo_level, 1);
        push(32'h1357_9BDF);
        frame(34, 32, l, r, we, pe);
        chk(l === 32'hCAFE_F00D && r === 32'h1357_9BDF, "R6 pair completed", l ^ r, 32'hCAFE_F00D ^ 32'h1357_9BDF);
        frame(34, 32, l, r, we, pe);
        chk(l === 0 && r === 0 && we == 0, "R7 underrun silent ws toggles", (l | r) + we, 0);
    endtask

    task automatic t_full();
        logic [31:0] l, r; int we, pe;
        configure(2'b00, 1'b1, 10); pulse_start();
        for (int i = 1; i <= 10; i++) push(32'(i));
        chk(fifo_level === 8, "R2 level capped at 8", fifo_level, 8);
        for (int i = 1; i <= 8; i++) begin
            frame(10, 8, l, r, we, pe);
            chk(l === 32'(i) && r === 32'(i), "R2 stored order", l, i);
        end
        frame(10, 8, l, r, we, pe);
        chk(l === 0 && r === 0, "R2 extra writes dropped", l, 0);
    endtask

    task automatic t_mute();
        logic [31:0] l, r; int we, pe;
        configure(2'b01, 1'b0, 20); pulse_start();
        push(32'h1111_2222); push(32'h3333_4444);
        pulse_stop();
        push(32'h5555_6666);
        chk(fifo_level === 2, "R8 write dropped while stopped", fifo_level, 2);
        frame(20, 16, l, r, we, pe);
        chk(l === 0 && r === 0 && pe == 0 && we == 0, "R8 muted frame", l | r, 0);
        chk(fifo_level === 2, "R8 contents kept", fifo_level, 2);
        pulse_start();
        frame(20, 16, l, r, we, pe);
        chk(l === 32'h2222 && r === 32'h1111, "R8 resume", {l[15:0], r[15:0]}, 32'h2222_1111);
    endtask

    task automatic t_flush();
        logic [31:0] l, r; int we, pe;
        configure(2'b01, 1'b0, 20); pulse_start();
        push(32'h1); push(32'h2); push(32'h3);
        pulse_flush();
        chk(fifo_level === 0, "R9 flush level", fifo_level, 0);
        frame(20, 16, l, r, we, pe);
        chk(l === 0 && r === 0, "R9 flushed data not sent", l | r, 0);
    endtask

    task automatic t_irq();
        configure(2'b01, 1'b0, 20); pulse_start();
        irq_thresh = 4'd2;
        for (int n = 0; n <= 3; n++) begin
            if (n > 0) push(32'(n));
            chk(level_irq === (n <= 2), "R10 level flag", level_irq, (n <= 2));
        end
        irq_thresh = 4'd0;
    endtask

    task automatic t_reserved();
        logic [31:0] l, r; int we, pe;
        configure(2'b01, 1'b1, 10);
        configure(2'b10, 1'b0, 20); pulse_start();
        push(32'hA5A5_0F0F);
        frame(20, 16, l, r, we, pe);
        chk(l === 32'h0F0F && r === 32'hA5A5 && we == 0, "R11 reserved keeps 16-bit", {l[15:0], r[15:0]}, 32'h0F0F_A5A5);
    endtask

    task automatic t_cfg_midframe();
        logic [31:0] l, r; int we, pe; logic ws, sd, ws2, sd2;
        configure(2'b01, 1'b0, 20); pulse_start();
        push(32'hFFFF_FFFF); push(32'hFFFF_FFFF);
        for (int k = 0; k < 5; k++) tick(ws, sd);
        repeat (3) @(negedge clk);
        chk(ws_out === ws && sd_out === sd, "R3 outputs hold between ticks", {ws_out, sd_out}, {ws, sd});
        configure(2'b01, 1'b0, 20);
        chk(ws_out === 0 && sd_out === 0 && fifo_level === 0, "R1 cfg write resets", {ws_out, sd_out, fifo_level}, 0);
        push(32'h4);
        chk(fifo_level === 0, "R1 stopped after cfg", fifo_level, 0);
        pulse_start();
        push(32'h8000_0001);
        frame(20, 16, l, r, we, pe);
        chk(l === 32'h0001 && r === 32'h8000 && we == 0, "R1 frame realigned", {l[15:0], r[15:0]}, 32'h0001_8000);
        tick(ws2, sd2);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_stereo16();
        t_stereo8();
        t_mono16();
        t_stereo32();
        t_full();
        t_mute();
        t_flush();
        t_irq();
        t_reserved();
        t_cfg_midframe();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule